// File: doc/BRIEF.md
# Staged Register File with Serial Slave Port

This block is a serial-peripheral slave that lets a host reach a 12-bit register address space. Every transfer opens with a 16-bit command word that holds a direction flag, a byte count and a starting address. One to three data bytes follow, most significant byte first. Register writes never reach the logic that uses the registers directly. They fill a staging copy. A later write of a commit bit moves the whole staging copy into the active copy in a single clock, so a group of related settings changes at the same instant.

The active copy of a parameterised window of general-purpose byte registers (`WIN_DEPTH` bytes starting at `WIN_BASE`) is presented in parallel on a flat output bus for the surrounding logic. Three control registers sit at fixed addresses outside that window:
- a port-configuration register that holds the serial-output enable and a soft-reset request;
- a read-source register that selects whether reads see the staged copy or the active copy;
- the commit register.

All serial inputs are oversampled by the block clock. The serial-output data and its enable leave the block as separate signals, so that the pad can realise the high-impedance state.

Top module: `sstg_spi_regfile`

## Requirements
- R1: Command word bit 15 selects the direction (1 = read, 0 = write), bits 14:13 hold the byte count minus one (1 to 3 bytes), and bits 11:0 hold the starting address. A write of N bytes changes exactly N register bytes.
- R2: Data moves most significant bit first within a byte and most significant byte first within a transfer. The first data byte belongs to the starting address, and each following byte belongs to the next higher address. A multi-byte read returns its value right-aligned in the same order.
- R3: A write into the window changes only the staged copy. The active-register bus does not change until a commit or a soft reset occurs.
- R4: Writing a byte with bit 0 = 1 to address 0x234 copies every staged register into the active copy one clock after that byte is taken. Reading address 0x234 returns 0. Writing it with bit 0 = 0 changes nothing.
- R5: Bit 0 of the register at address 0x004 selects the read source for the window: 1 returns staged contents and 0 returns active contents. The register reads back its own value.
- R6: Writing a byte with bit 5 = 1 to address 0x000 returns the staged copy, the active copy, the read-source bit and the configuration register to their reset values (all bytes 0x00, serial output enabled). Bit 5 always reads 0.
- R7: Bit 7 of address 0x000 enables the serial output. It is 1 after reset, and address 0x000 reads 0x80 in that state. While it is 0, `miso_en` stays low for the whole data phase of a read.
- R8: `miso_en` is high only while `cs_n` is low during the data bytes of a read. It is low during the command word, during writes, after the last counted byte, and whenever `cs_n` is high.
- R9: Raising `cs_n` before a byte has all 8 bits ends the transfer and discards the partial byte. The next transfer starts with a fresh command word.
- R10: Writes to addresses that are neither in the window nor a control register are ignored, and reads of such addresses return 0x00. Serial-clock edges after the counted bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to oversample the serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| cs_n | input | 1 | Active-low chip select that frames one transfer |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, valid while `miso_en` is high |
| miso_en | output | 1 | Output enable for the `miso` pad; low means high impedance |
| act_regs | output | WIN_DEPTH*8 | Active copy of the window; byte k is the register at WIN_BASE+k |

## Verification
The hardest situation to reach is a transfer that ends in the middle of a byte. Close behind it come multi-byte transfers in which a single command both stages data and then commits it or resets the block. The bench's transfer task takes an explicit number of serial-clock edges, so it can stop after a few data bits or clock past the counted bytes. Directed cases use that control to run truncated writes and overlong writes, and to disable and re-enable the serial output. A seeded random mix of window writes, reads from either copy, read-source changes and commits then runs against a byte-level model of both copies.

// File: rtl/sstg_pkg.sv
package sstg_pkg;
   localparam int ADDR_W = 12;
   localparam int BYTE_W = 8;
   localparam int CMD_W  = 16;

   localparam logic [ADDR_W-1:0] CFG_ADDR  = 12'h000;
   localparam logic [ADDR_W-1:0] RBK_ADDR  = 12'h004;
   localparam logic [ADDR_W-1:0] XFER_ADDR = 12'h234;

   localparam int CFG_SDO_BIT  = 7;
   localparam int CFG_SRST_BIT = 5;
   localparam int RBK_SEL_BIT  = 0;
   localparam int XFER_BIT     = 0;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_DATA = 2'd1,
      PH_END  = 2'd2
   } phase_t;
endpackage

// File: rtl/sstg_sync.sv
module sstg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic cs_n_i,
   input  logic mosi_i,
   output logic sclk_rise,
   output logic cs_hi,
   output logic mosi_s
);
   localparam logic [2:0] RST_PIPE = 3'b010;

   logic [STAGES-1:0][2:0] pipe;
   logic                   sclk_d;

   initial begin
      AST_PARAM_SYNC: assert (STAGES >= 2) else $error("sync depth below two");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe   <= {STAGES{RST_PIPE}};
         sclk_d <= 1'b0;
      end else begin
         pipe   <= {pipe[STAGES-2:0], {sclk_i, cs_n_i, mosi_i}};
         sclk_d <= pipe[STAGES-1][2];
      end
   end

   assign sclk_rise = pipe[STAGES-1][2] & ~sclk_d;
   assign cs_hi     = pipe[STAGES-1][1];
   assign mosi_s    = pipe[STAGES-1][0];
endmodule

// File: rtl/sstg_frame.sv
module sstg_frame
   import sstg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_hi,
   input  logic              sclk_rise,
   input  logic              mosi_s,
   input  logic [BYTE_W-1:0] rd_data,
   input  logic              sdo_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic              tx_bit,
   output logic              tx_en
);
   localparam int CNT_W = $clog2(CMD_W);
   localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);

   phase_t              ph;
   logic [CNT_W-1:0]    bcnt;
   logic [CMD_W-2:0]    sh;
   logic                is_rd;
   logic [1:0]          left;
   logic [ADDR_W-1:0]   cur;
   logic [BYTE_W-1:0]   tx;

   // command fields as they stand when the last command bit arrives
   logic              cmd_rd;
   logic [1:0]        cmd_cnt;
   logic [ADDR_W-1:0] cmd_addr;
   logic [BYTE_W-1:0] byte_in;

   assign cmd_rd   = sh[CMD_W-2];
   assign cmd_cnt  = sh[CMD_W-3:CMD_W-4];
   assign cmd_addr = {sh[ADDR_W-2:0], mosi_s};
   assign byte_in  = {sh[BYTE_W-2:0], mosi_s};

   // address whose byte is loaded at the next load point
   assign rd_addr = (ph == PH_CMD) ? cmd_addr : cur + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_CMD;
         bcnt    <= '0;
         sh      <= '0;
         is_rd   <= 1'b0;
         left    <= '0;
         cur     <= '0;
         tx      <= '0;
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (cs_hi) begin
            ph    <= PH_CMD;
            bcnt  <= '0;
            is_rd <= 1'b0;
            left  <= '0;
         end else if (sclk_rise) begin
            sh <= {sh[CMD_W-3:0], mosi_s};
            unique case (ph)
               PH_CMD: begin
                  if (bcnt == CMD_LAST) begin
                     ph    <= PH_DATA;
                     bcnt  <= '0;
                     is_rd <= cmd_rd;
                     left  <= cmd_cnt;
                     cur   <= cmd_addr;
                     tx    <= rd_data;
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               PH_DATA: begin
                  tx <= {tx[BYTE_W-2:0], 1'b0};
                  if (bcnt == BYTE_LAST) begin
                     bcnt <= '0;
                     if (!is_rd) begin
                        wr_stb  <= 1'b1;
                        wr_addr <= cur;
                        wr_data <= byte_in;
                     end
                     if (left == 2'd0) begin
                        ph <= PH_END;
                     end else begin
                        left <= left - 1'b1;
                        cur  <= cur + 1'b1;
                        tx   <= rd_data;
                     end
                  end else begin
                     bcnt <= bcnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign tx_bit = tx[BYTE_W-1];
   assign tx_en  = (ph == PH_DATA) && is_rd && sdo_en && !cs_hi;

   AST_WR_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !is_rd) else $error("write strobe during read"); // R1
   AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_DATA) |-> (bcnt <= BYTE_LAST)) else $error("data bit count overrun"); // R2
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> (ph == PH_CMD && bcnt == '0 && !wr_stb)) else $error("abort left state"); // R9
endmodule

// File: rtl/sstg_bank.sv
module sstg_bank
   import sstg_pkg::*;
#(
   parameter int                WIN_DEPTH = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 12'h010,
   parameter logic [BYTE_W-1:0] RST_VAL   = 8'h00,
   parameter bit                SDO_RST   = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_stb,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [BYTE_W-1:0]             wr_data,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [BYTE_W-1:0]             rd_data,
   output logic [WIN_DEPTH*BYTE_W-1:0]   act_flat,
   output logic                          sdo_en
);
   localparam int              IDX_W = (WIN_DEPTH > 1) ? $clog2(WIN_DEPTH) : 1;
   localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(WIN_BASE) + (ADDR_W+1)'(WIN_DEPTH);

   initial begin
      AST_PARAM_DEPTH: assert (WIN_DEPTH >= 2) else $error("window too small"); // R10
      AST_PARAM_WINDOW: assert (((WIN_BASE > RBK_ADDR) && (LIMIT <= {1'b0, XFER_ADDR}))
                                || ((WIN_BASE > XFER_ADDR) && (LIMIT <= 13'h1000)))
         else $error("window overlaps a control register"); // R10
   end

   function automatic logic hit_win(input logic [ADDR_W-1:0] a);
      return ({1'b0, a} >= {1'b0, WIN_BASE}) && ({1'b0, a} < LIMIT);
   endfunction

   logic [BYTE_W-1:0]               stg [WIN_DEPTH];
   logic [BYTE_W-1:0]               act [WIN_DEPTH];
   logic [WIN_DEPTH*BYTE_W-1:0]     stg_flat;
   logic                            rb_stage;
   logic                            upd_pend;
   logic                            srst_pend;
   logic                            wr_win;
   logic [IDX_W-1:0]                wr_idx;
   logic [IDX_W-1:0]                rd_idx;

   assign wr_win = wr_stb && hit_win(wr_addr);
   assign wr_idx = IDX_W'(wr_addr - WIN_BASE);
   assign rd_idx = IDX_W'(rd_addr - WIN_BASE);

   // control registers at fixed addresses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdo_en    <= SDO_RST;
         rb_stage  <= 1'b0;
         upd_pend  <= 1'b0;
         srst_pend <= 1'b0;
      end else if (srst_pend) begin
         sdo_en    <= SDO_RST;
         rb_stage  <= 1'b0;
         upd_pend  <= 1'b0;
         srst_pend <= 1'b0;
      end else begin
         upd_pend  <= 1'b0;
         srst_pend <= 1'b0;
         if (wr_stb) begin
            if (wr_addr == CFG_ADDR) begin
               sdo_en    <= wr_data[CFG_SDO_BIT];
               srst_pend <= wr_data[CFG_SRST_BIT];
            end else if (wr_addr == RBK_ADDR) begin
               rb_stage <= wr_data[RBK_SEL_BIT];
            end else if (wr_addr == XFER_ADDR) begin
               upd_pend <= wr_data[XFER_BIT];
            end
         end
      end
   end

   // one staged/active pair per window byte
   genvar g;
   generate
      for (g = 0; g < WIN_DEPTH; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg[g] <= RST_VAL;
               act[g] <= RST_VAL;
            end else if (srst_pend) begin
               stg[g] <= RST_VAL;
               act[g] <= RST_VAL;
            end else begin
               if (wr_win && (wr_idx == IDX_W'(g))) stg[g] <= wr_data;
               if (upd_pend) act[g] <= stg[g];
            end
         end
         assign act_flat[g*BYTE_W +: BYTE_W] = act[g];
         assign stg_flat[g*BYTE_W +: BYTE_W] = stg[g];
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_addr == CFG_ADDR) begin
         rd_data[CFG_SDO_BIT] = sdo_en;
      end else if (rd_addr == RBK_ADDR) begin
         rd_data[RBK_SEL_BIT] = rb_stage;
      end else if (hit_win(rd_addr)) begin
         rd_data = rb_stage ? stg[rd_idx] : act[rd_idx];
      end
   end

   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_pend && !srst_pend) |=> $stable(act_flat)) else $error("active copy moved"); // R3
   AST_UPD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pend |=> (act_flat == $past(stg_flat))) else $error("commit copy wrong"); // R4
   AST_UPD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      upd_pend |=> !upd_pend) else $error("commit not self-clearing"); // R4
   AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      srst_pend |=> ((act_flat == {WIN_DEPTH{RST_VAL}}) && (stg_flat == {WIN_DEPTH{RST_VAL}})
                     && !rb_stage && (sdo_en == SDO_RST))) else $error("soft reset incomplete"); // R6
endmodule

// File: rtl/sstg_spi_regfile.sv
module sstg_spi_regfile
   import sstg_pkg::*;
#(
   parameter int                WIN_DEPTH   = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE    = 12'h010,
   parameter logic [BYTE_W-1:0] RST_VAL     = 8'h00,
   parameter bit                SDO_RST     = 1'b1,
   parameter int                SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        sclk,
   input  logic                        cs_n,
   input  logic                        mosi,
   output logic                        miso,
   output logic                        miso_en,
   output logic [WIN_DEPTH*BYTE_W-1:0] act_regs
);
   logic              sclk_rise;
   logic              cs_hi;
   logic              mosi_s;
   logic [ADDR_W-1:0] rd_addr;
   logic [BYTE_W-1:0] rd_data;
   logic              wr_stb;
   logic [ADDR_W-1:0] wr_addr;
   logic [BYTE_W-1:0] wr_data;
   logic              sdo_en;
   logic              tx_bit;
   logic              tx_en;

   sstg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (sclk),
      .cs_n_i    (cs_n),
      .mosi_i    (mosi),
      .sclk_rise (sclk_rise),
      .cs_hi     (cs_hi),
      .mosi_s    (mosi_s)
   );

   sstg_frame u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_hi     (cs_hi),
      .sclk_rise (sclk_rise),
      .mosi_s    (mosi_s),
      .rd_data   (rd_data),
      .sdo_en    (sdo_en),
      .rd_addr   (rd_addr),
      .wr_stb    (wr_stb),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .tx_bit    (tx_bit),
      .tx_en     (tx_en)
   );

   sstg_bank #(
      .WIN_DEPTH (WIN_DEPTH),
      .WIN_BASE  (WIN_BASE),
      .RST_VAL   (RST_VAL),
      .SDO_RST   (SDO_RST)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_stb),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .act_flat  (act_regs),
      .sdo_en    (sdo_en)
   );

   assign miso    = tx_bit;
   assign miso_en = tx_en & ~cs_n;
endmodule

// File: tb/sim_sstg_spi_regfile.sv
module sim_sstg_spi_regfile;
   localparam int          DEPTH = 32;
   localparam logic [11:0] BASE  = 12'h010;
   localparam int          HALF  = 5;
   localparam int          BW    = DEPTH * 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic mosi = 1'b0;
   logic miso;
   logic miso_en;
   logic [BW-1:0] act_regs;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   logic [7:0] m_stg [DEPTH];
   logic [7:0] m_act [DEPTH];
   bit         m_sdo;
   bit         m_rb;

   always #4 clk = ~clk;

   sstg_spi_regfile #(.WIN_DEPTH(DEPTH), .WIN_BASE(BASE)) u0 (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
      .miso(miso), .miso_en(miso_en), .act_regs(act_regs)
   );

   task automatic check(input string tag, input logic [BW-1:0] got, input logic [BW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   function automatic bit in_win(input logic [11:0] a);
      return (int'(a) >= int'(BASE)) && (int'(a) < int'(BASE) + DEPTH);
   endfunction

   task automatic m_reset();
      for (int i = 0; i < DEPTH; i++) begin m_stg[i] = 8'h00; m_act[i] = 8'h00; end
      m_sdo = 1'b1;
      m_rb  = 1'b0;
   endtask

   task automatic m_write(input logic [11:0] a, input logic [7:0] d);
      if (a == 12'h000) begin
         m_sdo = d[7];
         if (d[5]) m_reset();
      end else if (a == 12'h004) begin
         m_rb = d[0];
      end else if (a == 12'h234) begin
         if (d[0]) for (int i = 0; i < DEPTH; i++) m_act[i] = m_stg[i];
      end else if (in_win(a)) begin
         m_stg[int'(a) - int'(BASE)] = d;
      end
   endtask

   function automatic logic [7:0] m_read(input logic [11:0] a);
      if (a == 12'h000) return {m_sdo, 7'b0};
      if (a == 12'h004) return {7'b0, m_rb};
      if (in_win(a)) return m_rb ? m_stg[int'(a) - int'(BASE)] : m_act[int'(a) - int'(BASE)];
      return 8'h00;
   endfunction

   function automatic logic [BW-1:0] m_bus();
      logic [BW-1:0] v;
      for (int i = 0; i < DEPTH; i++) v[i*8 +: 8] = m_act[i];
      return v;
   endfunction

   // nbits < 0 clocks exactly the command plus counted bytes
   task automatic xfer(input bit rd, input int n, input logic [11:0] a, input logic [23:0] wd,
                       input int nbits, output logic [23:0] rdat, output int en_lo, output int en_cmd);
      logic [15:0] cmd;
      int total;
      int lim;
      cmd    = {rd, 2'(n - 1), 1'b0, a};
      total  = 16 + 8 * n;
      lim    = (nbits < 0) ? total : nbits;
      rdat   = '0;
      en_lo  = 0;
      en_cmd = 0;
      @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int b = 0; b < lim; b++) begin
         if (b < 16) mosi = cmd[15 - b];
         else if (b < total) mosi = wd[8 * n - 1 - (b - 16)];
         else mosi = 1'b1;
         repeat (HALF) @(negedge clk);
         if (b < 16) begin
            if (miso_en) en_cmd++;
         end else if (b < total) begin
            if (!miso_en) en_lo++;
            rdat = {rdat[22:0], miso};
         end
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
   endtask

   task automatic do_wr(input int n, input logic [11:0] a, input logic [23:0] wd);
      logic [23:0] r;
      int e1;
      int e2;
      xfer(1'b0, n, a, wd, -1, r, e1, e2);
      for (int k = 0; k < n; k++) m_write(a + 12'(k), wd[8 * (n - 1 - k) +: 8]);
      check("R8 write keeps miso off", BW'(e1 == 8 * n && e2 == 0), BW'(1));
   endtask

   task automatic do_rd(input string tag, input int n, input logic [11:0] a);
      logic [23:0] r;
      logic [23:0] exp;
      int e1;
      int e2;
      exp = '0;
      for (int k = 0; k < n; k++) exp = {exp[15:0], m_read(a + 12'(k))};
      xfer(1'b1, n, a, 24'h0, -1, r, e1, e2);
      check({tag, " read data"}, BW'(r), BW'(exp));
      check("R8 miso enable window", BW'({e1 == 0, e2 == 0}), BW'(2'b11));
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [23:0] r;
      int e1;
      int e2;
      void'($urandom(32'h5EED_0042));
      m_reset();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // reset state
      check("R3 reset active bus", act_regs, '0);
      check("R8 idle miso_en", BW'(miso_en), BW'(0));
      do_rd("R7 cfg reset 0x80", 1, 12'h000);

      // staging, readback source and byte order
      do_wr(2, BASE, 24'h00A55A);
      check("R3 active unchanged after staging", act_regs, m_bus());
      do_rd("R5 active view", 2, BASE);
      do_wr(1, 12'h004, 24'h000001);
      do_rd("R5 rb reg", 1, 12'h004);
      do_rd("R2 staged order", 2, BASE);
      do_wr(3, BASE + 12'd4, 24'h123456);
      do_rd("R1 three bytes", 3, BASE + 12'd4);
      do_rd("R2 single middle byte", 1, BASE + 12'd5);

      // commit
      do_wr(1, 12'h234, 24'h000001);
      check("R4 commit copies", act_regs, m_bus());
      do_rd("R4 commit reads zero", 1, 12'h234);
      do_wr(1, BASE + 12'd1, 24'h0000C3);
      do_wr(1, 12'h234, 24'h000000);
      check("R4 zero commit ignored", act_regs, m_bus());

      // abort mid-byte
      xfer(1'b0, 1, BASE + 12'd2, 24'h0000FF, 16 + 5, r, e1, e2);
      check("R8 miso off after cs", BW'(miso_en), BW'(0));
      do_rd("R9 partial byte dropped", 1, BASE + 12'd2);
      do_rd("R9 next transfer clean", 2, BASE);

      // extra edges past the count, out-of-window write
      xfer(1'b0, 1, BASE + 12'd8, 24'h00007E, 16 + 16, r, e1, e2);
      m_write(BASE + 12'd8, 8'h7E);
      do_rd("R10 extra byte ignored", 2, BASE + 12'd8);
      do_wr(1, 12'h300, 24'h0000AA);
      do_rd("R10 unmapped reads zero", 1, 12'h300);

      // serial output disable
      do_wr(1, 12'h000, 24'h000000);
      xfer(1'b1, 1, BASE, 24'h0, -1, r, e1, e2);
      check("R7 sdo disabled keeps miso off", BW'(e1), BW'(8));
      do_wr(1, 12'h000, 24'h000080);
      do_rd("R7 sdo re-enabled", 1, 12'h000);

      // random mix
      for (int it = 0; it < 70; it++) begin
         int sel;
         int n;
         logic [11:0] a;
         sel = int'($urandom % 10);
         n   = 1 + int'($urandom % 3);
         if ($urandom % 8 == 0) a = 12'h240 + 12'($urandom % 12'hDB0);
         else a = BASE + 12'($urandom % DEPTH);
         if (sel < 4) begin
            do_wr(n, a, 24'($urandom));
            check("R3 random staging", act_regs, m_bus());
         end else if (sel < 7) begin
            do_rd("R5 random read", n, a);
         end else if (sel == 7) begin
            do_wr(1, 12'h004, 24'($urandom % 2));
         end else begin
            do_wr(1, 12'h234, 24'($urandom % 4 != 0));
            check("R4 random commit", act_regs, m_bus());
         end
      end

      // soft reset
      do_wr(1, 12'h234, 24'h000001);
      do_wr(1, 12'h004, 24'h000001);
      do_wr(1, 12'h000, 24'h0000A0);
      check("R6 soft reset active", act_regs, '0);
      do_rd("R6 rb cleared", 1, 12'h004);
      do_rd("R6 cfg after reset", 1, 12'h000);
      do_wr(1, 12'h004, 24'h000001);
      do_rd("R6 staged cleared", 3, BASE + 12'd3);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule